// File: doc/BRIEF.md
# Interrupt Pin Dispatch Engine

This block turns activity on a bank of interrupt input pins into message writes. It keeps one pending bit and one 64-bit redirection entry for each of 24 pins. Each entry says how its pin behaves:

- edge or level triggering;
- whether the pin is masked;
- the vector and delivery mode placed in the message;
- the destination placed in the message address.

Input events arrive as a pin number with a level. Input 0 is steered onto pin 2 before it is latched.

A request that needs service starts a scan. The scan walks the pins from index 0 upwards. Each deliverable pin produces one address/data pair on a valid/ready message port.

- **Level-triggered pins:** delivery sets the entry's remote-IRR bit. Further deliveries from that pin are held off until the surrounding logic clears the bit through the table write port.
- **Edge-triggered pins:** delivery consumes the pending bit.

Software-side logic owns the entries through a whole-entry write port and a combinational read port. Any table write also starts a scan. This lets a pin that became deliverable (unmasked, or remote-IRR cleared) be serviced without a new input event.

Top module: `irq_dispatch_engine`

## Requirements
- R1: After reset no message is offered and every entry reads 0x0000_0000_0001_0000 (only the mask bit, bit 16, set).
- R2: An event on input 0 acts on pin 2. Inputs 1 to 23 act on the pin of the same number. Inputs 24 and above change nothing and produce no message.
- R3: For an edge entry (bit 15 = 0), an event with level 1 on a masked entry is ignored, and a later unmask sends nothing. On an unmasked entry it produces exactly one message.
- R4: For a level entry (bit 15 = 1), level 1 sets the pin pending and level 0 clears it. Delivery sets remote-IRR (bit 14). While remote-IRR is set, further events on that pin send no message.
- R5: A table write that clears remote-IRR on a level pin whose input is still high causes one new message. With the input low, the same write sends none.
- R6: A pending pin whose entry is masked is skipped during a scan and stays pending. It is delivered after a table write unmasks it.
- R7: Message address is 0xFEE00000 | (destination[63:48] << 4) | (destination-mode bit 11 << 2). Message data is vector [7:0] in bits 7:0, delivery mode [10:8] in bits 10:8, trigger bit in bit 15, with all other bits zero.
- R8: The scan serves pins in ascending index order, at most one message per cycle. A valid message is held until msg_ready. Requests arriving during a scan cause a second scan after the current one ends.
- R9: A table write replaces all 64 bits of the addressed entry, and the read port returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_valid | input | 1 | Input event strobe |
| irq_num | input | 5 | Input number of the event |
| irq_level | input | 1 | Level carried by the event |
| tbl_wr_en | input | 1 | Entry write strobe |
| tbl_wr_idx | input | 5 | Entry index to write |
| tbl_wr_data | input | 64 | New entry value |
| tbl_rd_idx | input | 5 | Entry index to read |
| tbl_rd_data | output | 64 | Entry value at tbl_rd_idx (0 when out of range) |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted when high with msg_valid |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions check four rules on every cycle:

- pin 0 never becomes pending;
- an offered message never comes from a level pin whose remote-IRR is already set;
- a stalled message keeps its pin and content;
- a level delivery always leaves remote-IRR set.

Some behaviour can only be shown by the bench's scenarios, because it depends on the history of requests. This covers:

- the computed address and data for every pin;
- the input-0 rerouting;
- ignored masked edges;
- skipped-but-kept pending pins;
- redelivery after remote-IRR is cleared;
- the order produced by a rescan.

// File: rtl/irq_disp_pkg.sv
// Package: shared entry layout and message formatting for the dispatch engine.
// Assumes: 64-bit redirection entries with the field positions below.
package irq_disp_pkg;

    localparam logic [31:0] MSG_ADDR_BASE = 32'hFEE0_0000;

    typedef struct packed {
        logic [15:0] dest;      // 63:48
        logic [30:0] rsvd_hi;   // 47:17
        logic        mask;      // 16
        logic        trig;      // 15, 1 = level
        logic        rirr;      // 14
        logic [1:0]  rsvd_lo;   // 13:12
        logic        dmode;     // 11
        logic [2:0]  dlv;       // 10:8
        logic [7:0]  vec;       // 7:0
    } redir_t;

    localparam redir_t ENTRY_RESET = '{mask: 1'b1, default: '0};

    // Build the message address from an entry.
    function automatic logic [31:0] msg_addr_of(redir_t e);
        return MSG_ADDR_BASE | {12'h0, e.dest, 4'h0} | {29'h0, e.dmode, 2'b00};
    endfunction

    // Build the message data word from an entry.
    function automatic logic [31:0] msg_data_of(redir_t e);
        return {16'h0, e.trig, 4'h0, e.dlv, e.vec};
    endfunction

endpackage

// File: rtl/irq_redir_table.sv
// Module: storage for one redirection entry per pin.
// Does: whole-entry writes, a combinational read for software, a second
// read at the scan pointer, and remote-IRR setting on level delivery.
// Assumes: an external write in the same cycle as a delivery wins.
module irq_redir_table
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PW-1:0]       wr_idx,
    input  logic [63:0]         wr_data,
    input  logic [PW-1:0]       rd_idx,
    output logic [63:0]         rd_data,
    input  logic [PW-1:0]       scan_idx,
    output redir_t              scan_ent,
    input  logic                rirr_set,
    input  logic [PW-1:0]       rirr_idx,
    output logic [NUM_PINS-1:0] trig_vec,
    output logic [NUM_PINS-1:0] mask_vec,
    output logic [NUM_PINS-1:0] rirr_vec
);

    redir_t ent_q [NUM_PINS];

    // Per-entry storage: reset, external write, or remote-IRR set on delivery.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q[p] <= ENTRY_RESET;
            else if (wr_en && int'(wr_idx) == p)
                ent_q[p] <= redir_t'(wr_data);
            else if (rirr_set && int'(rirr_idx) == p)
                ent_q[p].rirr <= 1'b1;
        end
        assign trig_vec[p] = ent_q[p].trig;
        assign mask_vec[p] = ent_q[p].mask;
        assign rirr_vec[p] = ent_q[p].rirr;
    end

    // Software read port, zero outside the table.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < NUM_PINS) rd_data = 64'(ent_q[rd_idx]);
    end

    // Scan read port; the scan pointer never leaves the table.
    assign scan_ent = ent_q[scan_idx];

    // R4
    rirr_after_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set && !wr_en) |=> rirr_vec[$past(rirr_idx)]);

endmodule

// File: rtl/irq_pin_latch.sv
// Module: pending bits for all pins and the scan-start decision.
// Does: reroutes input 0 to pin 2, drops inputs past the table, applies
// edge/level rules, and clears edge pins once delivered.
// Assumes: an input event in the same cycle as a delivery of that pin wins.
module irq_pin_latch #(
    parameter int NUM_PINS  = 24,
    parameter int IN_W      = 5,
    parameter int REMAP_PIN = 2,
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic [IN_W-1:0]     ev_num,
    input  logic                ev_level,
    input  logic [NUM_PINS-1:0] trig_vec,
    input  logic [NUM_PINS-1:0] mask_vec,
    input  logic [NUM_PINS-1:0] rirr_vec,
    input  logic                clr_valid,
    input  logic [PW-1:0]       clr_idx,
    output logic [NUM_PINS-1:0] pend,
    output logic                kick
);

    logic [NUM_PINS-1:0] pend_q, pend_d;
    logic [PW-1:0]       pin;
    logic                in_range;

    // Map the input number onto a pin.
    assign in_range = int'(ev_num) < NUM_PINS;
    assign pin      = (ev_num == '0) ? PW'(REMAP_PIN) : PW'(ev_num);

    // Next pending vector and scan request from the event rules.
    always_comb begin
        pend_d = pend_q;
        kick   = 1'b0;
        if (clr_valid) pend_d[clr_idx] = 1'b0;
        if (ev_valid && in_range) begin
            if (trig_vec[pin]) begin
                pend_d[pin] = ev_level;
                kick        = ev_level && !rirr_vec[pin];
            end else if (ev_level && !mask_vec[pin]) begin
                pend_d[pin] = 1'b1;
                kick        = 1'b1;
            end
        end
    end

    // Pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

    // R2
    pin0_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0]);

endmodule

// File: rtl/irq_scan_fsm.sv
// Module: scan pointer and message former.
// Does: walks pins upwards one per cycle, stalls on an offered message until
// ready, and remembers scan requests that arrive mid-scan for one more pass.
// Assumes: scan_ent is the entry at ptr in the same cycle.
module irq_scan_fsm
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kick,
    input  logic [NUM_PINS-1:0] pend,
    input  redir_t              scan_ent,
    output logic [PW-1:0]       ptr,
    input  logic                msg_ready,
    output logic                msg_valid,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data,
    output logic                fire,
    output logic                fire_lvl
);

    logic          scan_q, again_q;
    logic [PW-1:0] ptr_q;
    logic          deliverable, step, last;
    logic          unused_rsvd;

    assign unused_rsvd = ^{scan_ent.rsvd_hi, scan_ent.rsvd_lo};

    // Decide whether the current pin sends a message and when to move on.
    assign deliverable = scan_q && pend[ptr_q] && !scan_ent.mask
                         && !(scan_ent.trig && scan_ent.rirr);
    assign step     = scan_q && (!deliverable || msg_ready);
    assign last     = int'(ptr_q) == NUM_PINS - 1;
    assign fire     = deliverable && msg_ready;
    assign fire_lvl = scan_ent.trig;

    // Scan state: idle/active, pointer, and the pending rescan flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q  <= 1'b0;
            again_q <= 1'b0;
            ptr_q   <= '0;
        end else if (!scan_q) begin
            again_q <= 1'b0;
            if (kick) begin
                scan_q <= 1'b1;
                ptr_q  <= '0;
            end
        end else if (step && last) begin
            again_q <= 1'b0;
            ptr_q   <= '0;
            if (!(again_q || kick)) scan_q <= 1'b0;
        end else begin
            if (step) ptr_q <= ptr_q + PW'(1);
            if (kick) again_q <= 1'b1;
        end
    end

    assign ptr       = ptr_q;
    assign msg_valid = deliverable;
    assign msg_addr  = msg_addr_of(scan_ent);
    assign msg_data  = msg_data_of(scan_ent);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> $stable(ptr_q) && scan_q);

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_q |-> !msg_valid);

endmodule

// File: rtl/irq_dispatch_engine.sv
// Module: top of the interrupt pin dispatch engine.
// Does: joins the pin latch, the redirection table and the scan engine; any
// table write also starts a scan so newly deliverable pins are serviced.
// Assumes: msg_ready may stay low for any number of cycles.
module irq_dispatch_engine
    import irq_disp_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int IN_W     = 5,
    localparam int PW = $clog2(NUM_PINS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            irq_valid,
    input  logic [IN_W-1:0] irq_num,
    input  logic            irq_level,
    input  logic            tbl_wr_en,
    input  logic [PW-1:0]   tbl_wr_idx,
    input  logic [63:0]     tbl_wr_data,
    input  logic [PW-1:0]   tbl_rd_idx,
    output logic [63:0]     tbl_rd_data,
    output logic            msg_valid,
    input  logic            msg_ready,
    output logic [31:0]     msg_addr,
    output logic [31:0]     msg_data
);

    logic [NUM_PINS-1:0] trig_vec, mask_vec, rirr_vec, pend;
    logic [PW-1:0]       ptr;
    redir_t              scan_ent;
    logic                pin_kick, fire, fire_lvl;

    irq_redir_table #(.NUM_PINS(NUM_PINS)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_data(tbl_wr_data),
        .rd_idx(tbl_rd_idx), .rd_data(tbl_rd_data),
        .scan_idx(ptr), .scan_ent(scan_ent),
        .rirr_set(fire && fire_lvl), .rirr_idx(ptr),
        .trig_vec(trig_vec), .mask_vec(mask_vec), .rirr_vec(rirr_vec)
    );

    irq_pin_latch #(.NUM_PINS(NUM_PINS), .IN_W(IN_W)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .ev_valid(irq_valid), .ev_num(irq_num), .ev_level(irq_level),
        .trig_vec(trig_vec), .mask_vec(mask_vec), .rirr_vec(rirr_vec),
        .clr_valid(fire && !fire_lvl), .clr_idx(ptr),
        .pend(pend), .kick(pin_kick)
    );

    irq_scan_fsm #(.NUM_PINS(NUM_PINS)) u_scan (
        .clk(clk), .rst_n(rst_n),
        .kick(pin_kick || tbl_wr_en), .pend(pend), .scan_ent(scan_ent),
        .ptr(ptr), .msg_ready(msg_ready), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data),
        .fire(fire), .fire_lvl(fire_lvl)
    );

    // R4
    no_coalesced_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> !(rirr_vec[ptr] && trig_vec[ptr]));

    // R8
    stall_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready && !tbl_wr_en && !irq_valid)
        |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

endmodule

// File: tb/test_irq_dispatch_engine.sv
module test_irq_dispatch_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_valid = 1'b0;
    logic [4:0]  irq_num = '0;
    logic        irq_level = 1'b0;
    logic        tbl_wr_en = 1'b0;
    logic [4:0]  tbl_wr_idx = '0;
    logic [63:0] tbl_wr_data = '0;
    logic [4:0]  tbl_rd_idx = '0;
    logic [63:0] tbl_rd_data;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [31:0] msg_addr, msg_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] log_a [64];
    logic [31:0] log_d [64];
    int          log_n = 0;

    always #10 clk = ~clk;  // 50 MHz

    irq_dispatch_engine i_irq_dispatch_engine (
        .clk(clk), .rst_n(rst_n),
        .irq_valid(irq_valid), .irq_num(irq_num), .irq_level(irq_level),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data),
        .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    // Record every accepted message.
    always @(posedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            if (log_n < 64) begin
                log_a[log_n] <= msg_addr;
                log_d[log_n] <= msg_data;
            end
            log_n <= log_n + 1;
        end
    end

    function automatic logic [15:0] dest_of(int p);
        return 16'(16'h0100 + p * 3);
    endfunction

    function automatic logic [63:0] mk_entry(int p, bit lvl, bit msk, bit ri);
        return {dest_of(p), 31'h0, msk, lvl, ri, 2'b00, 1'(p & 1),
                3'(p % 8), 8'(8'h30 + p)};
    endfunction

    function automatic logic [31:0] exp_addr(int p);
        return 32'hFEE0_0000 | (32'(dest_of(p)) << 4) | (32'(p & 1) << 2);
    endfunction

    function automatic logic [31:0] exp_data(int p, bit lvl);
        return {16'h0, lvl, 4'h0, 3'(p % 8), 8'(8'h30 + p)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse(input int num, input bit lvl);
        @(negedge clk);
        irq_valid = 1'b1; irq_num = 5'(num); irq_level = lvl;
        @(negedge clk);
        irq_valid = 1'b0;
    endtask

    task automatic wr(input int idx, input logic [63:0] val);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = 5'(idx); tbl_wr_data = val;
        @(negedge clk);
        tbl_wr_en = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [63:0] val);
        @(negedge clk);
        tbl_rd_idx = 5'(idx);
        #1 val = tbl_rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [63:0] v;
        int base;
        int pin;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of every entry and the message port
        chk(msg_valid == 1'b0, "R1 msg_valid", 64'(msg_valid), 64'd0);
        for (int p = 0; p < 24; p++) begin
            rd(p, v);
            chk(v == 64'h1_0000, "R1 entry", v, 64'h1_0000);
        end

        // R9: whole entry write and readback (masked, so nothing is sent)
        base = log_n;
        wr(20, 64'hA5C3_7E81_2345_B6FF);
        rd(20, v);
        chk(v == 64'hA5C3_7E81_2345_B6FF, "R9 readback", v, 64'hA5C3_7E81_2345_B6FF);
        settle(30);
        chk(log_n == base, "R9 no msg", 64'(log_n - base), 64'd0);

        // R2 R3 R7: sweep every input over unmasked edge entries
        for (int p = 0; p < 24; p++) wr(p, mk_entry(p, 1'b0, 1'b0, 1'b0));
        settle(30);
        for (int i = 0; i < 32; i++) begin
            base = log_n;
            pulse(i, 1'b1);
            settle(30);
            if (i >= 24) begin
                chk(log_n == base, "R2 out of range", 64'(log_n - base), 64'd0);
            end else begin
                pin = (i == 0) ? 2 : i;
                chk(log_n == base + 1, "R3 one message", 64'(log_n - base), 64'd1);
                chk(log_a[base] == exp_addr(pin), "R7 R2 address", 64'(log_a[base]),
                    64'(exp_addr(pin)));
                chk(log_d[base] == exp_data(pin, 1'b0), "R7 data", 64'(log_d[base]),
                    64'(exp_data(pin, 1'b0)));
            end
        end

        // R3: masked edge request ignored, unmask later sends nothing
        wr(11, mk_entry(11, 1'b0, 1'b1, 1'b0));
        base = log_n;
        pulse(11, 1'b1);
        settle(30);
        wr(11, mk_entry(11, 1'b0, 1'b0, 1'b0));
        settle(30);
        chk(log_n == base, "R3 masked edge ignored", 64'(log_n - base), 64'd0);

        // R4 R7: level pin delivers once, sets remote-IRR, then coalesces
        wr(7, mk_entry(7, 1'b1, 1'b0, 1'b0));
        settle(30);
        base = log_n;
        pulse(7, 1'b1);
        settle(30);
        chk(log_n == base + 1, "R4 level delivery", 64'(log_n - base), 64'd1);
        chk(log_d[base] == exp_data(7, 1'b1), "R7 level data", 64'(log_d[base]),
            64'(exp_data(7, 1'b1)));
        rd(7, v);
        chk(v[14] == 1'b1, "R4 remote-IRR set", 64'(v[14]), 64'd1);
        base = log_n;
        pulse(7, 1'b1);
        settle(30);
        chk(log_n == base, "R4 coalesced", 64'(log_n - base), 64'd0);

        // R5: clearing remote-IRR while input high redelivers
        base = log_n;
        wr(7, mk_entry(7, 1'b1, 1'b0, 1'b0));
        settle(30);
        chk(log_n == base + 1, "R5 redeliver", 64'(log_n - base), 64'd1);

        // R4 R5: input low clears pending; clearing remote-IRR then sends nothing
        base = log_n;
        pulse(7, 1'b0);
        wr(7, mk_entry(7, 1'b1, 1'b0, 1'b0));
        settle(30);
        chk(log_n == base, "R5 R4 low no msg", 64'(log_n - base), 64'd0);
        rd(7, v);
        chk(v[14] == 1'b0, "R5 remote-IRR clear", 64'(v[14]), 64'd0);

        // R6 R8: stalled message held, then masked pin skipped and kept
        msg_ready = 1'b0;
        base = log_n;
        pulse(9, 1'b1);
        settle(30);
        chk(msg_valid == 1'b1, "R8 held until ready", 64'(msg_valid), 64'd1);
        chk(msg_addr == exp_addr(9), "R8 held address", 64'(msg_addr), 64'(exp_addr(9)));
        wr(9, mk_entry(9, 1'b0, 1'b1, 1'b0));
        settle(2);
        chk(msg_valid == 1'b0, "R6 masked skipped", 64'(msg_valid), 64'd0);
        msg_ready = 1'b1;
        settle(30);
        chk(log_n == base, "R6 no msg while masked", 64'(log_n - base), 64'd0);
        wr(9, mk_entry(9, 1'b0, 1'b0, 1'b0));
        settle(30);
        chk(log_n == base + 1, "R6 delivered after unmask", 64'(log_n - base), 64'd1);
        chk(log_a[base] == exp_addr(9), "R6 address", 64'(log_a[base]), 64'(exp_addr(9)));

        // R8: ascending order within a scan, late lower pin served by rescan
        msg_ready = 1'b0;
        base = log_n;
        pulse(5, 1'b1);
        settle(10);
        pulse(17, 1'b1);
        pulse(3, 1'b1);
        settle(5);
        msg_ready = 1'b1;
        settle(60);
        chk(log_n == base + 3, "R8 count", 64'(log_n - base), 64'd3);
        chk(log_a[base] == exp_addr(5), "R8 first", 64'(log_a[base]), 64'(exp_addr(5)));
        chk(log_a[base + 1] == exp_addr(17), "R8 second", 64'(log_a[base + 1]),
            64'(exp_addr(17)));
        chk(log_a[base + 2] == exp_addr(3), "R8 rescan", 64'(log_a[base + 2]),
            64'(exp_addr(3)));

        done = 1'b1;
        summary();
    end

endmodule